// File: doc/BRIEF.md
# Three-Mode Boundary Wrapper for an Embedded Core

This block sits between the chip-level pins of one embedded core and the core itself. It inserts a short serial chain of boundary cells, one group on the core's input side and one on its output side. Two static selection pins choose among functional pass-through, a test of the logic outside the core (the wrapper drives the outgoing pin and samples the incoming pin), and a test of the core itself (the wrapper drives the core's input and samples its output).

The chain is clocked by its own wrapper clock and steered by an active-low scan enable. A low enable moves data serially from the scan input through the input-side cells and then the output-side cells to the scan output. A high enable lets the cells that the current mode selects load in parallel. The core and any scan structure inside it are outside this block. Only the core's data ports pass through it.

Top module: `wrap_boundary`

## Requirements
- R1: An active-low asynchronous reset clears every chain cell to 0. Immediately after reset, shifting shows 0 at `scan_out`.
- R2: With selection pins {`mode_sel_hi`,`mode_sel_lo`} = 2'b00 (functional), `pin_out` equals `core_out` and `core_in` equals `pin_in` combinationally.
- R3: The unused code 2'b11 behaves exactly as functional mode (R2 and R10).
- R4: With code 2'b01 (external test), `pin_out` shows the output-side cells and `core_in` still follows `pin_in`.
- R5: In external test with `scan_en_n` = 1, the input-side cells load `pin_in` on the rising edge of `wclk`. The output-side cells keep their value.
- R6: With code 2'b10 (internal test), `core_in` shows the input-side cells and `pin_out` shows the output-side cells.
- R7: In internal test with `scan_en_n` = 1, the output-side cells load `core_out` on the rising edge of `wclk`. The input-side cells keep their value.
- R8: With `scan_en_n` = 0, in any mode, every rising `wclk` edge shifts the chain. Cell 0 takes `scan_in`, and each cell takes the value of the cell below it. Input-side cells have the low indices. While `scan_en_n` = 0, `scan_out` shows the highest cell.
- R9: While `scan_en_n` = 1, `scan_out` is held at 0.
- R10: In functional mode with `scan_en_n` = 1, the chain keeps its contents across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Wrapper chain clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| mode_sel_hi | input | 1 | Upper bit of the static mode code |
| mode_sel_lo | input | 1 | Lower bit of the static mode code |
| scan_en_n | input | 1 | 0 shifts the chain, 1 loads in parallel |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from the last cell, 0 while not shifting |
| pin_in | input | IN_W | Chip-side signal headed into the core |
| pin_out | output | OUT_W | Chip-side signal coming from the core |
| core_in | output | IN_W | Drives the core's data input |
| core_out | input | OUT_W | The core's data output |

## Verification
The bench builds the block with its default widths: one input-side cell and one output-side cell, which gives the two-cell chain. With only two cells, a value written in through `scan_in` reaches `scan_out` after two edges. A parallel load in any mode can therefore be read back in two shifts, so every capture and every hold is observed at the ports within a few cycles. A random phase that mixes all four mode codes with shift and load steps covers mode changes that land between a load and its unload.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC = 2'd0,
        MODE_EXT  = 2'd1,
        MODE_INT  = 2'd2
    } wrap_mode_e;

    // Code 2'b11 is unused and falls back to functional operation.
    function automatic wrap_mode_e decode_mode(input logic hi, input logic lo);
        case ({hi, lo})
            2'b01:   return MODE_EXT;
            2'b10:   return MODE_INT;
            default: return MODE_FUNC;
        endcase
    endfunction

endpackage

// File: rtl/wrap_mode_dec.sv
module wrap_mode_dec
    import wrap_pkg::*;
(
    input  logic       sel_hi,
    input  logic       sel_lo,
    output wrap_mode_e mode
);
    always_comb begin
        mode = decode_mode(sel_hi, sel_lo);
    end
endmodule

// File: rtl/wrap_chain.sv
module wrap_chain
    import wrap_pkg::*;
#(
    parameter int IN_W  = 1,
    parameter int OUT_W = 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             shift_n,
    input  logic             ser_in,
    input  wrap_mode_e       mode,
    input  logic [IN_W-1:0]  pin_cap,
    input  logic [OUT_W-1:0] core_cap,
    output logic [IN_W-1:0]  in_cells,
    output logic [OUT_W-1:0] out_cells,
    output logic             tail
);
    localparam int LEN = IN_W + OUT_W;

    typedef struct packed {
        logic [LEN-1:0] cells;
    } chain_s;

    chain_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!shift_n) begin
            st_d.cells[0] = ser_in;
            for (int i = 1; i < LEN; i++) begin
                st_d.cells[i] = st_q.cells[i-1];
            end
        end else begin
            case (mode)
                MODE_EXT: st_d.cells[IN_W-1:0]   = pin_cap;
                MODE_INT: st_d.cells[LEN-1:IN_W] = core_cap;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_cells  = st_q.cells[IN_W-1:0];
    assign out_cells = st_q.cells[LEN-1:IN_W];
    assign tail      = st_q.cells[LEN-1];

    // R8: serial entry into cell 0
    p_shift_entry_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        !shift_n |=> st_q.cells[0] == $past(ser_in));

    generate
        for (genvar g = 1; g < LEN; g++) begin : g_shift_chk
            // R8: each cell takes its lower neighbour
            p_shift_move_r8: assert property (@(posedge wclk) disable iff (!rst_n)
                !shift_n |=> st_q.cells[g] == $past(st_q.cells[g-1]));
        end
    endgenerate

    // R5: input-side load in external test, output side kept
    p_ext_capture_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        (shift_n && mode == MODE_EXT) |=>
            (in_cells == $past(pin_cap)) && $stable(out_cells));

    // R7: output-side load in internal test, input side kept
    p_int_capture_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        (shift_n && mode == MODE_INT) |=>
            (out_cells == $past(core_cap)) && $stable(in_cells));

    // R10: functional mode leaves the chain alone when not shifting
    p_func_hold_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        (shift_n && mode == MODE_FUNC) |=> $stable(st_q.cells));

endmodule

// File: rtl/wrap_mux.sv
module wrap_mux
    import wrap_pkg::*;
#(
    parameter int IN_W  = 1,
    parameter int OUT_W = 1
) (
    input  wrap_mode_e       mode,
    input  logic             shift_n,
    input  logic [IN_W-1:0]  pin_in,
    input  logic [OUT_W-1:0] core_out,
    input  logic [IN_W-1:0]  in_cells,
    input  logic [OUT_W-1:0] out_cells,
    input  logic             tail,
    output logic [OUT_W-1:0] pin_out,
    output logic [IN_W-1:0]  core_in,
    output logic             scan_out
);
    always_comb begin
        pin_out  = (mode == MODE_FUNC) ? core_out : out_cells;
        core_in  = (mode == MODE_INT)  ? in_cells : pin_in;
        scan_out = shift_n ? 1'b0 : tail;
    end
endmodule

// File: rtl/wrap_boundary.sv
module wrap_boundary
    import wrap_pkg::*;
#(
    parameter int IN_W  = 1,
    parameter int OUT_W = 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             mode_sel_hi,
    input  logic             mode_sel_lo,
    input  logic             scan_en_n,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic [IN_W-1:0]  pin_in,
    output logic [OUT_W-1:0] pin_out,
    output logic [IN_W-1:0]  core_in,
    input  logic [OUT_W-1:0] core_out
);
    wrap_mode_e       mode;
    logic [IN_W-1:0]  in_cells;
    logic [OUT_W-1:0] out_cells;
    logic             tail;

    wrap_mode_dec u_dec (
        .sel_hi (mode_sel_hi),
        .sel_lo (mode_sel_lo),
        .mode   (mode)
    );

    wrap_chain #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chain (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .shift_n   (scan_en_n),
        .ser_in    (scan_in),
        .mode      (mode),
        .pin_cap   (pin_in),
        .core_cap  (core_out),
        .in_cells  (in_cells),
        .out_cells (out_cells),
        .tail      (tail)
    );

    wrap_mux #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mux (
        .mode      (mode),
        .shift_n   (scan_en_n),
        .pin_in    (pin_in),
        .core_out  (core_out),
        .in_cells  (in_cells),
        .out_cells (out_cells),
        .tail      (tail),
        .pin_out   (pin_out),
        .core_in   (core_in),
        .scan_out  (scan_out)
    );

    // R2 and R3: both functional codes pass data straight through
    p_func_pass_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (mode_sel_hi == mode_sel_lo) |-> (pin_out == core_out) && (core_in == pin_in));

    // R9: serial output silent outside shift
    p_scan_quiet_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        scan_en_n |-> scan_out == 1'b0);

    // R4: external test leaves the core input on the pin
    p_ext_core_in_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        (!mode_sel_hi && mode_sel_lo) |-> core_in == pin_in);

endmodule

// File: tb/wrap_boundary_tb_top.sv
module wrap_boundary_tb_top;

    logic wclk = 1'b0;
    logic rst_n;
    logic mode_sel_hi, mode_sel_lo, scan_en_n, scan_in;
    logic scan_out;
    logic [0:0] pin_in, pin_out, core_in, core_out;

    int checks   = 0;
    int failures = 0;
    bit chain_m[$];   // index 0 = cell 0 (input side), index 1 = cell 1 (output side)

    always #4 wclk = ~wclk;   // 125 MHz

    wrap_boundary dut_i (
        .wclk        (wclk),
        .rst_n       (rst_n),
        .mode_sel_hi (mode_sel_hi),
        .mode_sel_lo (mode_sel_lo),
        .scan_en_n   (scan_en_n),
        .scan_in     (scan_in),
        .scan_out    (scan_out),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .core_in     (core_in),
        .core_out    (core_out)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One cycle: drive at the falling edge, check outputs, then advance the model at the rising edge.
    task automatic step(input bit y, input bit z, input bit se_n, input bit si,
                        input bit pi, input bit co, input string tag);
        int code;
        bit e_so, e_po, e_ci;
        string po_tag, ci_tag;
        code = {y, z};
        mode_sel_hi = y; mode_sel_lo = z; scan_en_n = se_n;
        scan_in = si; pin_in = pi; core_out = co;
        #1;
        e_so = se_n ? 1'b0 : chain_m[1];
        if (code == 0 || code == 3) begin
            e_po = co; e_ci = pi;
            po_tag = (code == 3) ? "R3" : "R2"; ci_tag = po_tag;
        end else if (code == 1) begin
            e_po = chain_m[1]; e_ci = pi; po_tag = "R4"; ci_tag = "R4";
        end else begin
            e_po = chain_m[1]; e_ci = chain_m[0]; po_tag = "R6"; ci_tag = "R6";
        end
        chk(scan_out, e_so, se_n ? "R9" : tag, "scan_out");
        chk(pin_out[0], e_po, po_tag, "pin_out");
        chk(core_in[0], e_ci, ci_tag, "core_in");
        @(posedge wclk);
        if (!se_n) begin
            chain_m.push_front(si);
            void'(chain_m.pop_back());
        end else if (code == 1) begin
            chain_m[0] = pi;
        end else if (code == 2) begin
            chain_m[1] = co;
        end
        @(negedge wclk);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        checks++; failures++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin : main
        chain_m = '{1'b0, 1'b0};
        rst_n = 1'b0;
        mode_sel_hi = 0; mode_sel_lo = 0; scan_en_n = 0; scan_in = 1;
        pin_in = 0; core_out = 0;
        #20;
        chk(scan_out, 1'b0, "R1", "scan_out in reset");
        @(negedge wclk);
        rst_n = 1'b1;
        // R1: cleared cells shift out as zeros
        step(0, 0, 0, 1, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");

        // R8: load pattern 1 then 0, then unload
        step(0, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R8");

        // R10 and R2: chain holds 1,1 while functional traffic passes
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, k[0], k[1], "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");

        // R3: unused code acts as functional, also holds the chain
        step(1, 1, 0, 1, 0, 0, "R8");
        step(1, 1, 0, 0, 0, 0, "R8");
        for (int k = 0; k < 4; k++) step(1, 1, 1, 1, k[1], k[0], "R3");
        step(1, 1, 0, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, 0, "R3");

        // R4 and R5: external test
        step(0, 1, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 1, 0, 0, "R8");
        step(0, 1, 1, 0, 1, 0, "R5");
        step(0, 1, 0, 0, 0, 1, "R5");
        step(0, 1, 0, 0, 0, 1, "R5");
        step(0, 1, 1, 0, 0, 1, "R4");
        step(0, 1, 0, 0, 1, 1, "R5");

        // R6 and R7: internal test
        step(1, 0, 0, 1, 0, 0, "R8");
        step(1, 0, 0, 0, 1, 0, "R8");
        step(1, 0, 1, 0, 0, 1, "R7");
        step(1, 0, 0, 0, 1, 0, "R7");
        step(1, 0, 0, 0, 1, 0, "R7");
        step(1, 0, 1, 1, 1, 0, "R6");
        step(1, 0, 0, 0, 0, 0, "R7");

        // Mixed random traffic across all codes
        for (int k = 0; k < 300; k++) begin
            logic [5:0] r;
            r = 6'($urandom);
            step(r[0], r[1], r[2] & r[5], r[3], r[4], r[5] ^ r[0], "R8");
        end

        summary();
        $finish;
    end

endmodule